// File: doc/BRIEF.md
# Serial Word-Memory Command Slave

This block is the slave side of a four-wire serial command port in front of a small word-organised memory. The port has a select, a serial clock, a data input and a data output with its own output enable. A host raises select and may send any number of clocks with the data input low. These clocks do nothing. The first clock with the data input high is the start bit. A two-bit opcode and an address follow it. The block then reads, writes or erases a word, or it sets or clears a write-enable latch. A read keeps streaming words, incrementing the address, for as long as clocks arrive with select high.

Writes and erases go to a separate programming controller through a one-cycle request and a busy flag. The controller updates the register array after a fixed number of system cycles. The serial lines are sampled in the system clock domain. The block acts on a rising serial clock, found by comparing the serial clock with its value one system cycle earlier.

Control FSM states and transitions:
- ST_STBY: waits for a start bit. It goes to ST_OPC on a rising serial clock with data high, but only when no programming is pending.
- ST_OPC: collects two opcode bits, then goes to ST_ADR.
- ST_ADR: collects the address. After the last address bit it goes to ST_RD for a read, to ST_WR for a write, and to ST_HOLD for an erase or a control command.
- ST_RD, ST_WR and ST_HOLD stay where they are while select is high.
- Any state returns to ST_STBY on the first system cycle with select low.

The programming controller has two states. It goes from P_IDLE to P_BUSY on a request. It goes from P_BUSY back to P_IDLE after PROG_CYCLES cycles, and the array write fires on that transition.

Top module: `mw_cmd_slave`

## Requirements
- R1: While ser_sel is low, serial clocks and data have no effect, and ser_doe is low one system cycle after ser_sel is sampled low.
- R2: After ser_sel rises, rising serial clocks with ser_din low are ignored. The first rising serial clock with ser_din high is the start bit.
- R3: After the start bit come two opcode bits, first bit most significant: 10 = read, 01 = write, 11 = erase, 00 = control. The AW address bits follow, most significant first.
- R4: For control opcode 00, address bits [AW-1:AW-2] equal to 11 set the write-enable latch and 00 clear it. The values 01 and 10 leave the latch unchanged, and the lower address bits are ignored.
- R5: For a read, ser_doe goes high after the last address bit and ser_dout shows a single 0. On each following rising serial clock, ser_dout shows the word's bits from bit 15 down to bit 0.
- R6: While the read continues with ser_sel high, the next word follows with no gap. The address increments after each word and wraps from all ones to zero.
- R7: A write with more than 16 data bits stores only the last 16 bits received.
- R8: A write with fewer than 16 data bits stores those bits in the low-order positions, with the upper bits zero.
- R9: The write-enable latch is clear after reset. Write and erase commands are not carried out while it is clear.
- R10: An erase sets every bit of the addressed word to 1.
- R11: A programming request is issued only when ser_sel falls after a write or erase whose full address was received. A command cut short inside its address is discarded.
- R12: While a programming request is pending or in progress, start bits are ignored, so no read output appears and commands sent then are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel | input | 1 | Serial select, active high |
| ser_clk | input | 1 | Serial clock, acted on at its rising edge |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output bit |
| ser_doe | output | 1 | Output enable for ser_dout (low = high impedance) |

## Verification
The assertions check on every cycle that the output enable is low after select goes low and is high only in the read state. They also check that the enable latch changes only when an address completes, and that a programming request follows a deselect while the latch is set and never overlaps a busy controller. Only the scenarios can show the data itself. That covers the bit order and the leading zero of a read, streaming with wrap, keeping the last 16 bits of a long write, placing the bits of a short write, and erase giving all ones. It also covers dummy clocks and truncated commands having no effect, and commands sent during programming being lost.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [1:0] {
        OP_CTRL  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [2:0] {
        ST_STBY,
        ST_OPC,
        ST_ADR,
        ST_RD,
        ST_WR,
        ST_HOLD
    } mw_state_e;

    typedef enum logic {
        P_IDLE,
        P_BUSY
    } mw_pstate_e;
endpackage

// File: rtl/mw_rise_det.sv
module mw_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_prog_ctrl.sv
module mw_prog_ctrl
    import mw_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_erase,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    localparam int PCW = $clog2(PROG_CYCLES + 1);

    mw_pstate_e    pst, pst_nx;
    logic [PCW-1:0] pcnt;
    logic          done;

    assign done = (pcnt == PCW'(PROG_CYCLES - 1));

    always_comb begin
        pst_nx = pst;
        unique case (pst)
            P_IDLE: if (req)  pst_nx = P_BUSY;
            P_BUSY: if (done) pst_nx = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst <= P_IDLE;
        else        pst <= pst_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt  <= '0;
            we    <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else begin
            we <= 1'b0;
            unique case (pst)
                P_IDLE: if (req) begin
                    pcnt  <= '0;
                    waddr <= req_addr;
                    wdata <= req_erase ? {DW{1'b1}} : req_data;
                end
                P_BUSY: begin
                    pcnt <= pcnt + 1'b1;
                    if (done) we <= 1'b1;
                end
            endcase
        end
    end

    assign busy = (pst == P_BUSY) | we;

    // R12: the slave never issues a request while programming is under way
    a_r12_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !busy);

    // R11: programming starts only in response to a request
    a_r11_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pst == P_BUSY) |-> $past(req));
endmodule

// File: rtl/mw_cmd_slave.sv
module mw_cmd_slave
    import mw_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_sel,
    input  logic ser_clk,
    input  logic ser_din,
    output logic ser_dout,
    output logic ser_doe
);
    localparam int CNTW = $clog2(AW + DW);

    mw_state_e     state, state_nx;
    logic          rise;
    logic [CNTW-1:0] cnt;
    logic [1:0]    op_q;
    logic [AW-1:0] addr_q, addr_nx, rd_addr;
    logic [DW-1:0] shreg, dreg, rd_word;
    logic          wen_q;
    logic          req_q;
    logic          busy;
    logic          blocked;
    logic          adr_last;
    logic          cmd_pend;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;

    mw_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ser_clk),
        .rise  (rise)
    );

    assign blocked  = busy | req_q;
    assign addr_nx  = {addr_q[AW-2:0], ser_din};
    assign adr_last = (cnt == CNTW'(AW - 1));
    assign rd_addr  = (state == ST_ADR) ? addr_nx : AW'(addr_q + 1'b1);
    assign cmd_pend = (state == ST_WR) ||
                      ((state == ST_HOLD) && (op_q == OP_ERASE));

    // State register input
    always_comb begin
        state_nx = state;
        if (!ser_sel) begin
            state_nx = ST_STBY;
        end else if (rise) begin
            unique case (state)
                ST_STBY: if (ser_din && !blocked) state_nx = ST_OPC;
                ST_OPC:  if (cnt == CNTW'(1)) state_nx = ST_ADR;
                ST_ADR:  if (adr_last) begin
                    unique case (mw_op_e'(op_q))
                        OP_READ:  state_nx = ST_RD;
                        OP_WRITE: state_nx = ST_WR;
                        OP_ERASE: state_nx = ST_HOLD;
                        OP_CTRL:  state_nx = ST_HOLD;
                    endcase
                end
                ST_RD:   state_nx = ST_RD;
                ST_WR:   state_nx = ST_WR;
                ST_HOLD: state_nx = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STBY;
        else        state <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            shreg    <= '0;
            dreg     <= '0;
            wen_q    <= 1'b0;
            req_q    <= 1'b0;
            ser_dout <= 1'b0;
            ser_doe  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (!ser_sel) begin
                ser_doe <= 1'b0;
                if (cmd_pend && wen_q) req_q <= 1'b1;
            end else if (rise) begin
                unique case (state)
                    ST_STBY: cnt <= '0;
                    ST_OPC: begin
                        op_q <= {op_q[0], ser_din};
                        cnt  <= (cnt == CNTW'(1)) ? '0 : cnt + 1'b1;
                    end
                    ST_ADR: begin
                        addr_q <= addr_nx;
                        cnt    <= cnt + 1'b1;
                        if (adr_last) begin
                            cnt <= '0;
                            unique case (mw_op_e'(op_q))
                                OP_READ: begin
                                    ser_doe  <= 1'b1;
                                    ser_dout <= 1'b0;
                                    shreg    <= rd_word;
                                end
                                OP_WRITE: dreg <= '0;
                                OP_ERASE: ;
                                OP_CTRL: begin
                                    if (addr_nx[AW-1:AW-2] == 2'b11) wen_q <= 1'b1;
                                    if (addr_nx[AW-1:AW-2] == 2'b00) wen_q <= 1'b0;
                                end
                            endcase
                        end
                    end
                    ST_RD: begin
                        ser_dout <= shreg[DW-1];
                        if (cnt == CNTW'(DW - 1)) begin
                            cnt    <= '0;
                            addr_q <= rd_addr;
                            shreg  <= rd_word;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            shreg <= {shreg[DW-2:0], 1'b0};
                        end
                    end
                    ST_WR:   dreg <= {dreg[DW-2:0], ser_din};
                    ST_HOLD: ;
                endcase
            end
        end
    end

    mw_prog_ctrl #(
        .AW          (AW),
        .DW          (DW),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .req_erase (op_q == OP_ERASE),
        .req_addr  (addr_q),
        .req_data  (dreg),
        .busy      (busy),
        .we        (arr_we),
        .waddr     (arr_waddr),
        .wdata     (arr_wdata)
    );

    mw_word_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    // R1: deselect releases the output on the next cycle
    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sel |=> !ser_doe);

    // R5: the output is driven only while a read streams
    a_r5_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        ser_doe |-> (state == ST_RD));

    // R4: the enable latch moves only when an address completes
    a_r4_latch_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen_q) |-> $past(state == ST_ADR));

    // R9: a programming request needs the latch set
    a_r9_req_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> $past(wen_q));

    // R11: requests follow a deselect
    a_r11_req_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> !$past(ser_sel));
endmodule

// File: tb/tb_mw_cmd_slave.sv
`timescale 1ns/1ps
module tb_mw_cmd_slave;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int PROG  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_dout;
    logic ser_doe;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mw_cmd_slave #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_sel  (ser_sel),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_dout (ser_dout),
        .ser_doe  (ser_doe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        @(negedge clk);
        ser_din = b;
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic sel_on();
        @(negedge clk);
        ser_sel = 1'b1;
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk);
        ser_sel = 1'b0;
        ser_clk = 1'b0;
        ser_din = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_prog();
        repeat (PROG + 12) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        sel_on();
        clk_bit(1'b1);
        send(op, 2);
        send(a, AW);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int nb);
        cmd(2'b01, a);
        send(d, nb);
        sel_off();
        wait_prog();
    endtask

    task automatic ctl(input logic [1:0] top);
        cmd(2'b00, {top, 6'b101010});
        sel_off();
    endtask

    task automatic read_word(output logic [DW-1:0] w);
        w = '0;
        for (int i = 0; i < DW; i++) begin
            clk_bit(1'b0);
            w = {w[DW-2:0], ser_dout};
        end
    endtask

    task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] w;
        cmd(2'b10, a);
        chk({tag, " R5 lead oe"}, ser_doe, 1'b1);
        chk({tag, " R5 lead zero"}, ser_dout, 1'b0);
        read_word(w);
        chk(tag, w, exp);
        sel_off();
    endtask

    task automatic t_reset();
        chk("R1 reset oe", ser_doe, 1'b0);
    endtask

    task automatic t_refused();
        wr(8'd5, 32'h1234, 16);
        rd_check("R9 write refused after reset", 8'd5, 16'h0000);
    endtask

    task automatic t_basic();
        ctl(2'b11);
        sel_on();
        send(32'h0, 5);            // dummy clocks R2
        clk_bit(1'b1);
        send(2'b01, 2);
        send(8'd5, AW);
        send(32'hA5C3, 16);
        sel_off();
        wait_prog();
        rd_check("R2 R3 dummy clocks then write", 8'd5, 16'hA5C3);
    endtask

    task automatic t_long_short();
        wr(8'd7, 32'hF0F0F, 20);
        rd_check("R7 last 16 bits kept", 8'd7, 16'h0F0F);
        wr(8'd8, 32'h5, 3);
        rd_check("R8 short write low bits", 8'd8, 16'h0005);
    endtask

    task automatic t_erase();
        cmd(2'b11, 8'd7);
        sel_off();
        wait_prog();
        rd_check("R10 erase all ones", 8'd7, 16'hFFFF);
    endtask

    task automatic t_stream();
        logic [DW-1:0] w;
        wr(8'd255, 32'hBEEF, 16);
        wr(8'd0, 32'h1357, 16);
        cmd(2'b10, 8'd254);
        read_word(w);
        chk("R6 word 254", w, 16'h0000);
        read_word(w);
        chk("R6 word 255", w, 16'hBEEF);
        read_word(w);
        chk("R6 wrap to 0", w, 16'h1357);
        chk("R6 oe during stream", ser_doe, 1'b1);
        @(negedge clk);
        ser_sel = 1'b0;
        @(negedge clk);
        chk("R1 oe released at deselect", ser_doe, 1'b0);
        sel_off();
    endtask

    task automatic t_truncated();
        sel_on();
        clk_bit(1'b1);
        send(2'b11, 2);
        send(5'b00000, 5);
        sel_off();
        wait_prog();
        rd_check("R11 truncated erase discarded", 8'd5, 16'hA5C3);
    endtask

    task automatic t_busy();
        logic seen;
        wr_nowait(8'd9, 16'h4444);
        seen = 1'b0;
        cmd(2'b10, 8'd5);
        for (int i = 0; i < 4; i++) begin
            if (ser_doe) seen = 1'b1;
            clk_bit(1'b0);
        end
        chk("R12 read ignored while busy", seen, 1'b0);
        sel_off();
        wait_prog();
        wr_nowait(8'd10, 16'h5555);
        wr_nowait(8'd11, 16'h6666);
        wait_prog();
        rd_check("R12 first write done", 8'd10, 16'h5555);
        rd_check("R12 write during busy lost", 8'd11, 16'h0000);
    endtask

    task automatic wr_nowait(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd(2'b01, a);
        send(d, 16);
        sel_off();
    endtask

    task automatic t_latch();
        ctl(2'b00);
        wr(8'd5, 32'h0000, 16);
        rd_check("R4 R9 disable blocks write", 8'd5, 16'hA5C3);
        ctl(2'b01);
        wr(8'd5, 32'h0000, 16);
        rd_check("R4 code 01 keeps latch clear", 8'd5, 16'hA5C3);
        ctl(2'b11);
        ctl(2'b10);
        wr(8'd5, 32'h7E81, 16);
        rd_check("R4 code 10 keeps latch set", 8'd5, 16'h7E81);
    endtask

    task automatic t_standby();
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        ser_sel = 1'b0;
        for (int i = 0; i < 14; i++) begin
            ser_din = 1'b1;
            ser_clk = ~ser_clk;
            repeat (2) @(negedge clk);
            if (ser_doe) seen = 1'b1;
        end
        ser_clk = 1'b0;
        chk("R1 no output while deselected", seen, 1'b0);
        rd_check("R1 array untouched", 8'd5, 16'h7E81);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_refused();
        t_basic();
        t_long_short();
        t_erase();
        t_stream();
        t_truncated();
        t_busy();
        t_latch();
        t_standby();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule